// File: doc/BRIEF.md
# Write-through cache front end with posted store queue

This block sits between a processor load/store port and a word-wide memory port. It holds a small direct-mapped cache of four-word lines. The write policy is write-through without allocation on a write miss. Stores never wait for memory. Each accepted store goes into a four-entry posted queue, which drains to memory one word per handshake while the processor carries on. A store that hits the cache also updates the cached word in the same cycle, so the cache and memory agree once the queue has drained. A store that misses leaves the cache unchanged.

A load that hits returns its word combinationally in the cycle it is presented. A load that misses fetches its whole line from memory and then completes as a hit. If the queue still holds a store to that line, the controller first waits in a flush state until those stores have reached memory, so the fetched line is never stale. One memory port is shared by queue drains and line fetches. A fetch takes it first unless the queue is full. A transfer that has started keeps the port until its acknowledge.

The controller has three states. ST_IDLE serves hits and accepts stores. ST_FLUSH waits for conflicting queued stores to drain. ST_FILL fetches the line. The transitions are:
- IDLE→FLUSH: a read miss whose line is pending in the queue.
- IDLE→FILL: a read miss with no such conflict.
- FLUSH→FILL: the last conflicting entry has left the queue.
- FILL→IDLE: the fourth fetched word is acknowledged.

Top module: `wt_cache`

Addresses are word addresses of 10 bits. Bits [1:0] select the word in the line, bits [4:2] select the set, and bits [9:5] form the tag. A memory transfer completes on a clock edge where both `mem_req` and `mem_ack` are high. `mem_we` = 1 marks a store drain and 0 marks a line-fetch read. The processor keeps its request stable until `cpu_ready` is high.

## Requirements
- R1: After reset every valid bit is clear, `mem_req` is low, and the first load to any address is a miss that stalls and goes to memory.
- R2: A load that hits asserts `cpu_ready` in the same cycle and returns the cached word, with no memory traffic.
- R3: A load miss fetches its line with four memory reads at line offsets 0, 1, 2, 3 in that order. After the fetch the load completes with the correct word, and loads to the rest of that line hit.
- R4: A store hit updates the cached word at once, so a following load hit returns the new value. The store is also sent to memory exactly once.
- R5: A store miss causes no memory read and does not disturb the line held in its set. The word reaches memory through the queue.
- R6: A store is accepted in the cycle it is presented while fewer than 4 stores are queued. With 4 queued it stalls until an entry drains.
- R7: Queued stores reach memory in acceptance order, one write per handshake, each with its own address and data.
- R8: A line fetch never starts while the queue holds a store to that line. Such stores drain first, and the load returns the stored value.
- R9: While a fetch is pending and the queue is not full, the fetch reads take the memory port ahead of queued stores. A full queue gets the port first.
- R10: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 10 | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = queue drain write, 0 = line-fetch read |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 32 | Drain write data |
| mem_ack | input | 1 | Transfer completes at this edge |
| mem_rdata | input | 32 | Fetch read data, valid with `mem_ack` |

## Verification
Most wrong internal state here shows up on the very next load. A stale valid bit or tag turns an expected miss into a zero-stall hit that returns the wrong word. A lost store-hit update returns old data in the cycle right after the store. Queue pointer or ordering faults appear only once the queue drains, as writes with the wrong address, data or sequence in the memory log, a few handshakes later. Arbitration and flush faults show up as fetch reads placed ahead of a conflicting write, or behind a write they should precede, in that same log.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    // Four words per line is fixed by the line-fetch behaviour.
    localparam int LINE_OFF_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_FILL  = 2'd2
    } ctl_state_t;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_DRAIN = 2'd1,
        OWN_FILL  = 2'd2
    } port_owner_t;
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  live_q;
    logic [DEPTH-1:0]  match;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            live_q <= '0;
        end else begin
            if (push) begin
                live_q[wr_ptr] <= 1'b1;
                wr_ptr         <= step(wr_ptr);
            end
            if (pop) begin
                live_q[rd_ptr] <= 1'b0;
                rd_ptr         <= step(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    // Line comparison against every live entry, for the read-after-write hazard.
    for (genvar g = 0; g < DEPTH; g++) begin : g_probe
        assign match[g] = live_q[g] && (addr_q[g][ADDR_W-1 -: LINE_W] == probe_line);
    end

    assign probe_hit = |match;
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !full); // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (!empty && live_q[rd_ptr])); // R7
endmodule

// File: rtl/wtc_store.sv
module wtc_store #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 5,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [OFF_W-1:0]  lk_off,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inval,
    input  logic [IDX_W-1:0]  inval_idx,
    input  logic              mark,
    input  logic [IDX_W-1:0]  mark_idx,
    input  logic [TAG_W-1:0]  mark_tag
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] word_q [SETS*WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (inval) valid_q[inval_idx] <= 1'b0;
            if (mark)  valid_q[mark_idx]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (mark)  tag_q[mark_idx]           <= mark_tag;
        if (wr_en) word_q[{wr_idx, wr_off}] <= wr_data;
    end

    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_word = word_q[{lk_idx, lk_off}];
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 3,
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import wtc_pkg::*;

    localparam int OFF_W  = LINE_OFF_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int WORDS  = 1 << OFF_W;

    ctl_state_t  state_q, state_d;
    port_owner_t owner_q, grant;
    logic        lock_q;
    logic [LINE_W-1:0] fill_line_q;
    logic [OFF_W-1:0]  fill_cnt_q;

    logic [IDX_W-1:0]  c_idx;
    logic [OFF_W-1:0]  c_off;
    logic [TAG_W-1:0]  c_tag;
    logic [LINE_W-1:0] c_line;
    assign c_off  = cpu_addr[OFF_W-1:0];
    assign c_idx  = cpu_addr[OFF_W +: IDX_W];
    assign c_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign c_line = cpu_addr[ADDR_W-1 -: LINE_W];

    logic              hit;
    logic [DATA_W-1:0] hit_word;
    logic              wb_empty, wb_full, wb_push, wb_pop, probe_hit;
    logic [ADDR_W-1:0] wb_head_addr;
    logic [DATA_W-1:0] wb_head_data;
    logic [LINE_W-1:0] probe_line;
    logic              is_rd, is_wr, rd_miss, xfer, fill_beat, fill_last;
    logic              st_wr_en;
    logic [IDX_W-1:0]  st_wr_idx;
    logic [OFF_W-1:0]  st_wr_off;
    logic [DATA_W-1:0] st_wr_data;

    assign is_rd      = cpu_req && !cpu_we;
    assign is_wr      = cpu_req && cpu_we;
    assign rd_miss    = (state_q == ST_IDLE) && is_rd && !hit;
    assign probe_line = (state_q == ST_IDLE) ? c_line : fill_line_q;
    assign xfer       = mem_req && mem_ack;
    assign fill_beat  = xfer && (grant == OWN_FILL);
    assign wb_pop     = xfer && (grant == OWN_DRAIN);
    assign fill_last  = (fill_cnt_q == OFF_W'(WORDS - 1));

    wtc_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_store (
        .clk(clk), .rst(rst),
        .lk_idx(c_idx), .lk_tag(c_tag), .lk_off(c_off), .lk_hit(hit), .lk_word(hit_word),
        .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_off(st_wr_off), .wr_data(st_wr_data),
        .inval(rd_miss), .inval_idx(c_idx),
        .mark(fill_beat && fill_last), .mark_idx(fill_line_q[IDX_W-1:0]),
        .mark_tag(fill_line_q[LINE_W-1:IDX_W])
    );

    wtc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH), .LINE_W(LINE_W)) u_wbuf (
        .clk(clk), .rst(rst),
        .push(wb_push), .push_addr(cpu_addr), .push_data(cpu_wdata),
        .pop(wb_pop), .head_addr(wb_head_addr), .head_data(wb_head_data),
        .empty(wb_empty), .full(wb_full),
        .probe_line(probe_line), .probe_hit(probe_hit)
    );

    // State register and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            owner_q     <= OWN_NONE;
            lock_q      <= 1'b0;
            fill_line_q <= '0;
            fill_cnt_q  <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= grant;
            lock_q  <= mem_req && !mem_ack;
            if (rd_miss) begin
                fill_line_q <= c_line;
                fill_cnt_q  <= '0;
            end else if (fill_beat) begin
                fill_cnt_q <= fill_cnt_q + 1'b1;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rd_miss) state_d = probe_hit ? ST_FLUSH : ST_FILL;
            ST_FLUSH: if (!probe_hit) state_d = ST_FILL;
            ST_FILL:  if (fill_beat && fill_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Memory port arbitration: a started transfer keeps its owner.
    always_comb begin
        if (lock_q)
            grant = owner_q;
        else if ((state_q == ST_FILL) && !wb_full)
            grant = OWN_FILL;
        else if (!wb_empty)
            grant = OWN_DRAIN;
        else if (state_q == ST_FILL)
            grant = OWN_FILL;
        else
            grant = OWN_NONE;
    end

    // Outputs.
    always_comb begin
        cpu_ready  = 1'b0;
        wb_push    = 1'b0;
        st_wr_en   = 1'b0;
        st_wr_idx  = c_idx;
        st_wr_off  = c_off;
        st_wr_data = cpu_wdata;
        unique case (state_q)
            ST_IDLE: begin
                if (is_wr && !wb_full) begin
                    cpu_ready = 1'b1;
                    wb_push   = 1'b1;
                    st_wr_en  = hit;
                end else if (is_rd && hit) begin
                    cpu_ready = 1'b1;
                end
            end
            ST_FILL: begin
                st_wr_en   = fill_beat;
                st_wr_idx  = fill_line_q[IDX_W-1:0];
                st_wr_off  = fill_cnt_q;
                st_wr_data = mem_rdata;
            end
            default: ;
        endcase
        cpu_rdata = hit_word;
        mem_req   = (grant != OWN_NONE);
        mem_we    = (grant == OWN_DRAIN);
        mem_addr  = (grant == OWN_DRAIN) ? wb_head_addr : {fill_line_q, fill_cnt_q};
        mem_wdata = (grant == OWN_DRAIN) ? wb_head_data : '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && state_q == ST_IDLE)); // R1
    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
        (fill_beat && fill_last && is_rd) |=> cpu_ready); // R3
    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !probe_hit); // R8
    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                   && $stable(mem_wdata))); // R10
endmodule

// File: tb/tb_wt_cache.sv
`timescale 1ns/1ps
module tb_wt_cache;
    localparam int LAT = 4;
    localparam int NV  = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [9:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk; // 50 MHz

    wt_cache dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem     [1024];
    logic [31:0] ref_mem [1024];
    logic        log_we   [256];
    logic [9:0]  log_addr [256];
    logic [31:0] log_data [256];
    int          log_n = 0;
    int          n_tests = 0, n_fail = 0, hold_err = 0, wait_cnt = 0;
    logic [9:0]  held_addr;
    logic        held_we;
    logic [31:0] held_data;
    bit          done = 1'b0;

    function automatic logic [31:0] init_word(input int a);
        return 32'h5000_0000 + 32'(a) * 32'h0001_0001;
    endfunction

    // Memory model: acknowledges after LAT waiting cycles, logs every transfer.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack  = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                held_addr = mem_addr; held_we = mem_we; held_data = mem_wdata;
            end else if (mem_addr !== held_addr || mem_we !== held_we
                         || (mem_we && mem_wdata !== held_data)) begin
                hold_err++;
            end
            if (wait_cnt == LAT) begin
                mem_ack = 1'b1;
                if (log_n < 256) begin
                    log_we[log_n] = mem_we; log_addr[log_n] = mem_addr; log_data[log_n] = mem_wdata;
                    log_n++;
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else        mem_rdata = mem[mem_addr];
            end else begin
                wait_cnt++;
            end
        end else if (wait_cnt != 0) begin
            hold_err++;
            wait_cnt = 0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [9:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int stall);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        stall = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1;
            stall++;
        end
        rd = cpu_rdata;
        if (we) ref_mem[a] = d;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    function automatic int find(input logic we, input logic [9:0] a);
        for (int k = 0; k < log_n; k++)
            if (log_we[k] == we && log_addr[k] == a) return k;
        return -1;
    endfunction

    function automatic int count_reads();
        int c = 0;
        for (int k = 0; k < log_n; k++) if (!log_we[k]) c++;
        return c;
    endfunction

    // {store, miss expected, address, store data}
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 1'b1, 10'h010, 32'h0},          // R1 R3 cold miss
        {1'b0, 1'b0, 10'h013, 32'h0},          // R2 hit in fetched line
        {1'b1, 1'b0, 10'h011, 32'h1111_0001},  // R4 store hit
        {1'b0, 1'b0, 10'h011, 32'h0},          // R4 new value from cache
        {1'b1, 1'b0, 10'h200, 32'h2222_0002},  // R5 store miss
        {1'b0, 1'b1, 10'h201, 32'h0},          // R8 line pending in queue
        {1'b0, 1'b0, 10'h200, 32'h0},          // R8 stored word after fetch
        {1'b0, 1'b1, 10'h030, 32'h0},          // R3 replaces set 4
        {1'b0, 1'b1, 10'h011, 32'h0},          // R3 refetch drained value
        {1'b1, 1'b0, 10'h3FF, 32'h3333_0003},  // R5 store miss top line
        {1'b0, 1'b1, 10'h3FC, 32'h0},          // R8 conflict on same line
        {1'b0, 1'b0, 10'h3FF, 32'h0}           // R2 hit after fetch
    };

    initial begin
        logic        we_v, miss_v;
        logic [9:0]  a_v;
        logic [31:0] d_v, exp_v, rd;
        int          st;
        int          stalls [5];
        int          p_w, p_r, p_last;

        for (int a = 0; a < 1024; a++) begin
            mem[a] = init_word(a);
            ref_mem[a] = init_word(a);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1 mem_req idle after reset", {31'b0, mem_req}, 32'd0);
        check("R1 cpu_ready idle after reset", {31'b0, cpu_ready}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            {we_v, miss_v, a_v, d_v} = VEC[i];
            exp_v = ref_mem[a_v];
            cpu_op(we_v, a_v, d_v, rd, st);
            if (!we_v) check($sformatf("R2/R3 vector %0d load data", i), rd, exp_v);
            check($sformatf("R1/R2 vector %0d stall", i), {31'b0, st > 0}, {31'b0, miss_v});
        end
        settle();

        // R3: fetch order and following hits
        log_n = 0;
        cpu_op(1'b0, 10'h145, 32'h0, rd, st);
        check("R3 fetched word", rd, ref_mem[10'h145]);
        check("R3 four reads", 32'(log_n), 32'd4);
        for (int k = 0; k < 4; k++) begin
            check("R3 read kind", {31'b0, log_we[k]}, 32'd0);
            check("R3 read order", {22'b0, log_addr[k]}, {22'b0, 10'h144 + 10'(k)});
        end
        cpu_op(1'b0, 10'h147, 32'h0, rd, st);
        check("R3 line neighbour hits", 32'(st), 32'd0);
        check("R3 line neighbour data", rd, ref_mem[10'h147]);
        check("R3 no extra traffic", 32'(log_n), 32'd4);

        // R4: store hit updates cache and memory once
        settle(); log_n = 0;
        cpu_op(1'b1, 10'h146, 32'hA5A5_0146, rd, st);
        cpu_op(1'b0, 10'h146, 32'h0, rd, st);
        check("R4 load after store hit", rd, 32'hA5A5_0146);
        check("R4 no stall", 32'(st), 32'd0);
        settle();
        check("R4 one memory write", 32'(log_n), 32'd1);
        check("R4 write address", {22'b0, log_addr[0]}, {22'b0, 10'h146});
        check("R4 write data", log_data[0], 32'hA5A5_0146);

        // R5: store miss, no allocation
        log_n = 0;
        cpu_op(1'b1, 10'h2A0, 32'h5A5A_02A0, rd, st);
        check("R5 store miss accepted at once", 32'(st), 32'd0);
        settle();
        check("R5 no fetch on store miss", 32'(count_reads()), 32'd0);
        check("R5 write reached memory", {31'b0, find(1'b1, 10'h2A0) >= 0}, 32'd1);
        cpu_op(1'b0, 10'h200, 32'h0, rd, st);
        check("R5 resident line kept", 32'(st), 32'd0);
        check("R5 resident data", rd, 32'h2222_0002);
        cpu_op(1'b0, 10'h2A0, 32'h0, rd, st);
        check("R5 later load misses", {31'b0, st > 0}, 32'd1);
        check("R5 later load data", rd, 32'h5A5A_02A0);

        // R6 / R7: queue depth and drain order
        settle(); log_n = 0;
        for (int j = 0; j < 5; j++) begin
            cpu_op(1'b1, 10'h300 + 10'(j), 32'hB000_0000 + 32'(j), rd, st);
            stalls[j] = st;
        end
        for (int j = 0; j < 4; j++) check("R6 store accepted while room", 32'(stalls[j]), 32'd0);
        check("R6 fifth store stalls", {31'b0, stalls[4] > 0}, 32'd1);
        settle();
        check("R7 five writes", 32'(log_n), 32'd5);
        for (int j = 0; j < 5; j++) begin
            check("R7 drain address order", {22'b0, log_addr[j]}, {22'b0, 10'h300 + 10'(j)});
            check("R7 drain data", log_data[j], 32'hB000_0000 + 32'(j));
        end

        // R8: load miss to a line with a queued store
        log_n = 0;
        cpu_op(1'b1, 10'h0E0, 32'hC0C0_00E0, rd, st);
        cpu_op(1'b0, 10'h0E2, 32'h0, rd, st);
        check("R8 load data", rd, ref_mem[10'h0E2]);
        p_w = find(1'b1, 10'h0E0);
        p_r = find(1'b0, 10'h0E0);
        check("R8 write before fetch", {31'b0, (p_w >= 0) && (p_r > p_w)}, 32'd1);
        cpu_op(1'b0, 10'h0E0, 32'h0, rd, st);
        check("R8 fetched line holds store", rd, 32'hC0C0_00E0);

        // R9: fetch overtakes a non-full queue
        settle(); log_n = 0;
        cpu_op(1'b1, 10'h340, 32'hD000_0340, rd, st);
        cpu_op(1'b1, 10'h354, 32'hD000_0354, rd, st);
        cpu_op(1'b0, 10'h188, 32'h0, rd, st);
        check("R9 load data", rd, ref_mem[10'h188]);
        settle();
        p_last = find(1'b0, 10'h18B);
        p_w    = find(1'b1, 10'h354);
        check("R9 fetch before queued store", {31'b0, (p_last >= 0) && (p_w > p_last)}, 32'd1);

        check("R10 request held until ack", 32'(hold_err), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule